// File: doc/BRIEF.md
# Receive Character Queue with Error Reporting Modes

This block sits between a serial receiver and the register interface a CPU uses. Each time the receiver finishes a character, it hands the block a data byte and three quality flags: parity error, framing error and line break. The block holds up to three such characters in arrival order. Together with the receiver's own shift stage, that gives four characters of slack between the line and software. The oldest character is always on the read data output. A CPU read strobe removes it, together with its flags.

The block drives a status word. It has a ready flag (at least one character waiting), a full flag (all slots occupied) and a sticky overrun flag. The overrun flag is set when a character arrives with nowhere to go, and it is not stored with any character. It also carries three error outputs, and a mode input decides what they mean. In per-character mode they show the flags of the oldest stored character. In accumulate mode each one is the running OR of that flag over every character that has become the oldest entry since software last issued the clear-errors command. Accumulate mode lets software check a whole message once at its end. An interrupt request follows either the ready flag or the full flag, as a select input chooses.

Top module: `rx_fifo_errstat`

## Requirements
- R1: After reset the queue is empty: ready, full, overrun, the three error outputs and the interrupt request are all low.
- R2: Ready is high whenever one or more characters are stored. Full is high exactly when three are stored.
- R3: The read data output shows the oldest stored character. A read strobe removes it, and a later character takes its place in arrival order. A read strobe on an empty queue changes nothing.
- R4: A character offered while the queue is full and no read strobe is present is discarded and sets the overrun flag. The stored characters are unchanged.
- R5: A character offered on a full queue in the same cycle as a read strobe is stored, the oldest is removed, and overrun is not set.
- R6: With the mode input low (per-character mode), the parity, framing and break outputs equal the flags of the oldest stored character.
- R7: With the mode input high (accumulate mode), each error output is the OR of that flag over all characters that reached the oldest position since the last clear. A character is counted once, when it reaches that position. A clear issued while it stays there removes its contribution.
- R8: The clear-errors strobe zeroes the accumulated error flags and the overrun flag and leaves stored characters untouched.
- R9: With the select input low, the interrupt request equals ready. With it high, the interrupt request equals full.
- R10: While the queue is empty, the three error outputs are low in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Receiver offers a completed character this cycle |
| push_data_i | input | 8 | Received data byte |
| push_pe_i | input | 1 | Parity error flag of the offered character |
| push_fe_i | input | 1 | Framing error flag of the offered character |
| push_brk_i | input | 1 | Break flag of the offered character |
| pop_i | input | 1 | CPU read strobe; removes the oldest character |
| mode_acc_i | input | 1 | 0 = per-character error reporting, 1 = accumulate mode |
| err_clr_i | input | 1 | Clear-errors command strobe |
| irq_sel_full_i | input | 1 | 0 = interrupt on ready, 1 = interrupt on full |
| rd_data_o | output | 8 | Data byte of the oldest stored character |
| rdy_o | output | 1 | At least one character stored |
| full_o | output | 1 | All three slots occupied |
| ovr_o | output | 1 | Sticky overrun flag |
| pe_o | output | 1 | Parity error status |
| fe_o | output | 1 | Framing error status |
| brk_o | output | 1 | Break status |
| irq_o | output | 1 | Interrupt request |

## Verification
A new character can reach the head of the queue in the same cycle that a read or a clear-errors command arrives. These collisions are where the block's functions can go wrong. The bench provokes them on purpose. It offers a character and a read strobe together on a full queue, and it expects both to be accepted with overrun staying low. It also issues a clear while a flagged character stays at the head, and it expects the accumulated flags to read zero with no recount. The scoreboard judges each case. It tracks every character by a sequence number and ORs in its flags the first time that number is at the head.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  parameter int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [DATA_W-1:0] data;
  } ent_t;

  function automatic logic [2:0] ent_flags(ent_t e);
    return {e.brk, e.fe, e.pe};
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  ent_t push_ent_i,
  input  logic pop_i,
  output ent_t top_o,
  output logic rdy_o,
  output logic full_o,
  output logic ovf_evt_o,
  output logic arrive_o,
  output ent_t arrive_ent_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  ent_t             mem [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rdy_o     = (cnt_q != '0);
  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign pop_ok    = pop_i && rdy_o;
  assign push_ok   = push_i && (!full_o || pop_ok);
  assign ovf_evt_o = push_i && !push_ok;
  assign top_o     = mem[head_q];

  // A character becomes the head entry on this edge
  assign arrive_o = (push_ok && (cnt_q == '0))
                 || (push_ok && pop_ok && (cnt_q == CNT_W'(1)))
                 || (pop_ok && (cnt_q > CNT_W'(1)));
  assign arrive_ent_o = (cnt_q > CNT_W'(1)) ? mem[ptr_inc(head_q)] : push_ent_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) tail_q <= ptr_inc(tail_q);
      if (pop_ok)  head_q <= ptr_inc(head_q);
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) mem[i] <= '0;
      else if (push_ok && (tail_q == PTR_W'(i))) mem[i] <= push_ent_i;
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r3_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_o && pop_i && !push_i) |=> !rdy_o);
  a_r5_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && pop_i) |=> full_o);
endmodule

// File: rtl/rxf_errmode.sv
module rxf_errmode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       arrive_i,
  input  logic [2:0] arrive_flags_i,
  input  logic       ovf_evt_i,
  output logic [2:0] acc_o,
  output logic       ovr_o
);
  logic [2:0] acc_q;
  logic       ovr_q;
  logic [2:0] acc_base;

  assign acc_base = clr_i ? 3'b000 : acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      acc_q <= acc_base | (arrive_i ? arrive_flags_i : 3'b000);
      ovr_q <= (clr_i ? 1'b0 : ovr_q) | ovf_evt_i;
    end
  end

  assign acc_o = acc_q;
  assign ovr_o = ovr_q;

  a_r7_acc_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((acc_q & $past(acc_q)) == $past(acc_q)));
  a_r4_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt_i |=> ovr_q);
  a_r8_clr_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !ovf_evt_i) |=> !ovr_q);
  a_r8_clr_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !arrive_i) |=> (acc_q == 3'b000));
endmodule

// File: rtl/rx_fifo_errstat.sv
module rx_fifo_errstat
  import rxf_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              push_pe_i,
  input  logic              push_fe_i,
  input  logic              push_brk_i,
  input  logic              pop_i,
  input  logic              mode_acc_i,
  input  logic              err_clr_i,
  input  logic              irq_sel_full_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rdy_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              brk_o,
  output logic              irq_o
);
  ent_t       push_ent, top_ent, arrive_ent;
  logic       ovf_evt, arrive;
  logic [2:0] acc, sel_flags;

  assign push_ent = '{brk: push_brk_i, fe: push_fe_i, pe: push_pe_i, data: push_data_i};

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push_i),
    .push_ent_i   (push_ent),
    .pop_i        (pop_i),
    .top_o        (top_ent),
    .rdy_o        (rdy_o),
    .full_o       (full_o),
    .ovf_evt_o    (ovf_evt),
    .arrive_o     (arrive),
    .arrive_ent_o (arrive_ent)
  );

  rxf_errmode u_err (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr_i          (err_clr_i),
    .arrive_i       (arrive),
    .arrive_flags_i (ent_flags(arrive_ent)),
    .ovf_evt_i      (ovf_evt),
    .acc_o          (acc),
    .ovr_o          (ovr_o)
  );

  assign sel_flags = rdy_o ? (mode_acc_i ? acc : ent_flags(top_ent)) : 3'b000;
  assign pe_o      = sel_flags[0];
  assign fe_o      = sel_flags[1];
  assign brk_o     = sel_flags[2];
  assign rd_data_o = top_ent.data;
  assign irq_o     = irq_sel_full_i ? full_o : rdy_o;

  a_r2_full_implies_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> rdy_o);
  a_r10_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_o |-> !(pe_o || fe_o || brk_o));
  a_r5_no_ovr_on_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && pop_i && !ovr_o) |=> !ovr_o);
endmodule

// File: tb/sim_rx_fifo_errstat.sv
module sim_rx_fifo_errstat;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_i = 0, pop_i = 0, mode_acc_i = 0, err_clr_i = 0, irq_sel_full_i = 0;
  logic [7:0] push_data_i = 0;
  logic       push_pe_i = 0, push_fe_i = 0, push_brk_i = 0;
  logic [7:0] rd_data_o;
  logic       rdy_o, full_o, ovr_o, pe_o, fe_o, brk_o, irq_o;

  always #4 clk = ~clk;

  rx_fifo_errstat u0 (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  // scoreboard entries: {id, brk, fe, pe, data}
  typedef struct { int id; logic [2:0] fl; logic [7:0] d; } item_t;
  item_t q[$];
  int    next_id = 0, last_top = -1;
  logic [2:0] m_acc = 0;
  logic       m_ovr = 0;

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_status(string req);
    logic [2:0] e;
    e = (q.size() == 0) ? 3'b000 : (mode_acc_i ? m_acc : q[0].fl);
    chk(req, "rdy", 8'(rdy_o), 8'(q.size() > 0));
    chk(req, "full", 8'(full_o), 8'(q.size() == 3));
    chk(req, "ovr", 8'(ovr_o), 8'(m_ovr));
    chk(req, "err{brk,fe,pe}", 8'({brk_o, fe_o, pe_o}), 8'(e));
    chk("R9", "irq", 8'(irq_o), 8'(irq_sel_full_i ? (q.size() == 3) : (q.size() > 0)));
  endtask

  // one clock: drive at negedge, compare head on read, update model after edge
  task automatic step(bit psh, logic [7:0] d, logic [2:0] fl, bit pop, bit clr);
    bit had, acc_push;
    push_i = psh; push_data_i = d; {push_brk_i, push_fe_i, push_pe_i} = fl;
    pop_i = pop; err_clr_i = clr;
    had = (q.size() > 0);
    if (pop && had) chk("R3", "head data on read", rd_data_o, q[0].d);
    @(posedge clk);
    @(negedge clk);
    push_i = 0; pop_i = 0; err_clr_i = 0;
    acc_push = psh && (q.size() < 3 || (pop && had));
    if (clr) begin m_acc = 0; m_ovr = 0; end
    if (psh && !acc_push) m_ovr = 1;
    if (pop && had) void'(q.pop_front());
    if (acc_push) begin q.push_back('{next_id, fl, d}); next_id++; end
    if (q.size() > 0 && q[0].id != last_top) begin
      m_acc |= q[0].fl;
      last_top = q[0].id;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_status("R1");
    chk("R1", "irq", 8'(irq_o), 8'd0);

    // per-character mode, fill up
    step(1, 8'hA1, 3'b001, 0, 0); check_status("R6");
    chk("R3", "head data", rd_data_o, 8'hA1);
    step(1, 8'hB2, 3'b010, 0, 0); check_status("R2");
    step(1, 8'hC3, 3'b100, 0, 0); check_status("R2");
    irq_sel_full_i = 1; #1; check_status("R9");
    // overrun on full
    step(1, 8'hDD, 3'b111, 0, 0); check_status("R4");
    chk("R4", "head unchanged", rd_data_o, 8'hA1);
    // clear: overrun drops, data kept
    step(0, 0, 0, 0, 1); check_status("R8");
    chk("R8", "head kept", rd_data_o, 8'hA1);
    // push and pop together on full
    step(1, 8'hE4, 3'b000, 1, 0); check_status("R5");
    chk("R5", "ovr stays low", 8'(ovr_o), 8'd0);
    irq_sel_full_i = 0;
    // drain, checking order and per-entry flags
    for (int i = 0; i < 3; i++) begin step(0, 0, 0, 1, 0); check_status("R6"); end
    chk("R3", "empty", 8'(rdy_o), 8'd0);
    step(0, 0, 0, 1, 0); check_status("R3");
    step(1, 8'h5A, 3'b000, 1, 0); check_status("R3");
    chk("R3", "push on empty with read", rd_data_o, 8'h5A);
    step(0, 0, 0, 1, 0); check_status("R10");

    // accumulate mode
    mode_acc_i = 1;
    step(0, 0, 0, 0, 1); check_status("R10");
    step(1, 8'h11, 3'b001, 0, 0); check_status("R7");
    step(1, 8'h22, 3'b000, 0, 0); check_status("R7");
    step(1, 8'h33, 3'b010, 0, 0); check_status("R7");
    step(0, 0, 0, 1, 0); check_status("R7");
    chk("R7", "pe kept after pop", 8'(pe_o), 8'd1);
    step(0, 0, 0, 0, 1); check_status("R7");
    chk("R7", "clear with clean head", 8'({brk_o, fe_o, pe_o}), 8'd0);
    step(0, 0, 0, 1, 0); check_status("R7");
    chk("R7", "fe on arrival", 8'(fe_o), 8'd1);
    step(0, 0, 0, 0, 1); check_status("R7");
    chk("R7", "counted once", 8'(fe_o), 8'd0);
    mode_acc_i = 0; #1; check_status("R6");
    chk("R6", "per-char fe", 8'(fe_o), 8'd1);
    // clear together with arrival: new head counted
    mode_acc_i = 1;
    step(1, 8'h44, 3'b100, 1, 1); check_status("R7");
    step(0, 0, 0, 1, 0); check_status("R10");
    mode_acc_i = 0; #1; check_status("R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule